// File: doc/BRIEF.md
# Serial Command/Data Register Port

This block is a four-line synchronous serial slave that gives a host access to the registers of a converter-style peripheral. The lines are an active-low select, a bit clock, a data input and a data output. The select, the bit clock and the data input are brought into the system clock domain through two-flop synchronisers. Bit-clock edges are then found by comparing the synchronised clock with its value one cycle earlier. Only edges seen while the select is low are acted on.

Every access starts with an 8-bit command byte. A write command is followed by 32 data bits, which are loaded into the addressed register when the last bit arrives. A register read command is followed by 32 clocks during which the port shifts the register contents out. A conversion read is different: 8 clocks first clear the data-ready flag, and 32 clocks of the latched conversion word follow. The port returns to command mode after each access. It can therefore run with the select held low permanently, as a three-wire link.

Conversion results arrive on a parallel input with a valid strobe. Between data phases the data output carries the inverted data-ready flag.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, offset_o and cfg_o are 0 and gain_o is 0x0100_0000. The data-ready flag is clear, so sdo_o reads 1 in the command phase.
- R2: sdo_en_o is 1 exactly while cs_ni is 0. While sdo_en_o is 0 the data output is treated as high impedance.
- R3: Bits are sampled on rising bit-clock edges, MSB first. A command byte of 0x01, 0x02 or 0x03, followed by 32 bits, writes the offset, gain or configuration register in that order.
- R4: Command bytes 0x09, 0x0A and 0x0B read the offset, gain and configuration registers. sdo_o changes on falling edges. The register MSB appears on the falling edge that follows the 8th command rising edge, and the other bits follow MSB first over 32 clocks.
- R5: After the 32-bit phase of any access the port waits for a new command byte. Back-to-back accesses work with cs_ni held low throughout.
- R6: Command byte 0x0C starts a conversion read. It is followed by 8 flag-clear clocks and then 32 clocks of the word last latched from conv_data_i, MSB first.
- R7: A pulse on conv_valid_i latches conv_data_i and sets the ready flag. During the command phase and the flag-clear phase, sdo_o is the inverted flag (0 means data is ready). The flag clears on the 8th rising edge of the flag-clear phase.
- R8: Raising cs_ni part-way through an access aborts it. No register changes, and the next access starts with a command byte.
- R9: Any other command byte is ignored. No register changes and the port stays in command mode, so a command byte that follows at once is decoded.
- R10: Bit-clock edges while cs_ni is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial bit clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Output enable for sdo_o; 0 means high impedance |
| conv_valid_i | input | 1 | Strobe: a new conversion word is on conv_data_i |
| conv_data_i | input | 32 | Conversion result |
| offset_o | output | 32 | Offset register |
| gain_o | output | 32 | Gain register |
| cfg_o | output | 32 | Configuration register |

## Verification
Any corruption of the bit counter or of the phase state is visible within one access. A miscounted command phase shifts the read-back data by whole bits, or leaves a register unchanged after a write. A phase that does not return to command mode makes the second access in a held-select sequence decode garbage. A ready flag that clears at the wrong moment shows on sdo_o in the next command phase. The flag-clear phase shows the flag on every one of its 8 clocks.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int CMD_W = 8;

  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,
    ST_WDATA = 2'd1,
    ST_CLR   = 2'd2,
    ST_RDATA = 2'd3
  } srp_state_e;

  // register select in cmd[1:0]: 1 offset, 2 gain, 3 config
  localparam logic [1:0] SEL_OFS  = 2'd1;
  localparam logic [1:0] SEL_GAIN = 2'd2;
  localparam logic [1:0] SEL_CFG  = 2'd3;

  localparam logic [CMD_W-1:0] CMD_CONV = 8'h0C;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int          W      = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {2{RST_VAL[g]}};
      else         ff_q <= {ff_q[0], d_i[g]};
    end
    assign q_o[g] = ff_q[1];
  end
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile #(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] GAIN_RST = 32'h0100_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              conv_valid_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic              clr_ready_i,
  output logic [DATA_W-1:0] offset_o,
  output logic [DATA_W-1:0] gain_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] conv_o,
  output logic              ready_o
);
  localparam int NREG = 3;

  logic [DATA_W-1:0] regs_q [NREG];
  logic [DATA_W-1:0] conv_q;
  logic              ready_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RV = (g == 1) ? GAIN_RST : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[g] <= RV;
      else if (wr_en_i && wr_sel_i == 2'(g + 1)) regs_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      if (conv_valid_i) conv_q <= conv_data_i;
      // a new result wins over a clear in the same cycle
      if (conv_valid_i)     ready_q <= 1'b1;
      else if (clr_ready_i) ready_q <= 1'b0;
    end
  end

  assign offset_o = regs_q[0];
  assign gain_o   = regs_q[1];
  assign cfg_o    = regs_q[2];
  assign conv_o   = conv_q;
  assign ready_o  = ready_q;

  assert_ready_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_q) |-> $past(clr_ready_i));

  assert_no_stray_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(offset_o) && $stable(gain_o) && $stable(cfg_o)));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] GAIN_RST = 32'h0100_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  input  logic              conv_valid_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic [DATA_W-1:0] offset_o,
  output logic [DATA_W-1:0] gain_o,
  output logic [DATA_W-1:0] cfg_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  logic sclk_s, cs_s, sdi_s, sclk_d;
  logic rise, fall, cs_act;

  srp_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, cs_ni, sclk_i}),
    .q_o   ({sdi_s, cs_s, sclk_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end

  assign cs_act = !cs_s;
  assign rise   = cs_act &&  sclk_s && !sclk_d;
  assign fall   = cs_act && !sclk_s &&  sclk_d;

  srp_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] in_sh_q, out_sh_q;
  logic [1:0]        sel_q;
  logic              sdo_q;

  logic [DATA_W-1:0] shifted;
  logic [CMD_W-1:0]  cmd;
  logic              is_wr, is_rd;
  logic [DATA_W-1:0] rd_mux, conv_w;
  logic              ready, wr_en, clr_ready;

  assign shifted = {in_sh_q[DATA_W-2:0], sdi_s};
  assign cmd     = shifted[CMD_W-1:0];
  assign is_wr   = (cmd[CMD_W-1:2] == '0) && (cmd[1:0] != 2'd0);
  assign is_rd   = (cmd[CMD_W-1:4] == '0) && (cmd[3:2] == 2'b10) && (cmd[1:0] != 2'd0);

  always_comb begin
    unique case (cmd[1:0])
      SEL_OFS:  rd_mux = offset_o;
      SEL_GAIN: rd_mux = gain_o;
      SEL_CFG:  rd_mux = cfg_o;
      default:  rd_mux = '0;
    endcase
  end

  assign wr_en     = rise && (state_q == ST_WDATA) && (cnt_q == DATA_LAST);
  assign clr_ready = rise && (state_q == ST_CLR)   && (cnt_q == CMD_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_CMD;
      cnt_q    <= '0;
      in_sh_q  <= '0;
      out_sh_q <= '0;
      sel_q    <= '0;
      sdo_q    <= 1'b1;
    end else if (cs_s) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
    end else if (rise) begin
      in_sh_q <= shifted;
      cnt_q   <= cnt_q + 1'b1;
      unique case (state_q)
        ST_CMD: if (cnt_q == CMD_LAST) begin
          cnt_q <= '0;
          sel_q <= cmd[1:0];
          if (is_wr) state_q <= ST_WDATA;
          else if (is_rd) begin
            state_q  <= ST_RDATA;
            out_sh_q <= rd_mux;
          end else if (cmd == CMD_CONV) state_q <= ST_CLR;
        end
        ST_CLR: if (cnt_q == CMD_LAST) begin
          cnt_q    <= '0;
          state_q  <= ST_RDATA;
          out_sh_q <= conv_w;
        end
        ST_WDATA, ST_RDATA: if (cnt_q == DATA_LAST) begin
          cnt_q   <= '0;
          state_q <= ST_CMD;
        end
        default: state_q <= ST_CMD;
      endcase
    end else if (fall) begin
      if (state_q == ST_RDATA) begin
        sdo_q    <= out_sh_q[DATA_W-1];
        out_sh_q <= {out_sh_q[DATA_W-2:0], 1'b0};
      end else begin
        sdo_q <= !ready;
      end
    end
  end

  srp_regfile #(.DATA_W(DATA_W), .GAIN_RST(GAIN_RST)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_sel_i    (sel_q),
    .wr_data_i   (shifted),
    .conv_valid_i(conv_valid_i),
    .conv_data_i (conv_data_i),
    .clr_ready_i (clr_ready),
    .offset_o    (offset_o),
    .gain_o      (gain_o),
    .cfg_o       (cfg_o),
    .conv_o      (conv_w),
    .ready_o     (ready)
  );

  assign sdo_o    = sdo_q;
  assign sdo_en_o = !cs_ni;

  assert_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (state_q == ST_CMD && cnt_q == '0));

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RDATA || state_q == ST_WDATA) |-> (cnt_q < CNT_W'(DATA_W)));

  assert_short_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD || state_q == ST_CLR) |-> (cnt_q < CNT_W'(CMD_W)));

  assert_idle_edges_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> $stable(sdo_q));
endmodule

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic conv_valid = 1'b0;
  logic [31:0] conv_data = '0;
  logic sdo, sdo_en;
  logic [31:0] offset, gain, cfg;

  int checks = 0, errors = 0, cycles = 0;
  bit quiet = 1'b0;

  // reference model state
  logic [31:0] m_reg [4];
  logic [31:0] m_conv = '0;
  bit          m_ready = 1'b0;

  always #4 clk = ~clk;

  serial_reg_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .conv_valid_i(conv_valid),
    .conv_data_i(conv_data), .offset_o(offset), .gain_o(gain), .cfg_o(cfg)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(sdo_en == !cs_n, "R2 output enable", 32'(sdo_en), 32'(!cs_n));
      if (quiet) begin
        chk(offset == m_reg[1], "R3 offset vs model", offset, m_reg[1]);
        chk(gain   == m_reg[2], "R3 gain vs model",   gain,   m_reg[2]);
        chk(cfg    == m_reg[3], "R3 config vs model", cfg,    m_reg[3]);
      end
    end
  end

  initial begin
    wait (cycles > 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected <200000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic bit_x(input logic b, output logic o);
    sdi = b; sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    o = sdo;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic tx_begin();
    quiet = 1'b0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tx_end();
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    quiet = 1'b1;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n, output logic [31:0] got);
    logic o;
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bit_x(v[i], o);
      got[i] = o;
    end
  endtask

  task automatic do_write(input logic [7:0] code, input logic [31:0] d);
    logic [31:0] g;
    send_bits(32'(code), 8, g);
    send_bits(d, 32, g);
    m_reg[code[1:0]] = d;
  endtask

  task automatic do_read(input logic [7:0] code, input string tag);
    logic [31:0] g;
    send_bits(32'(code), 8, g);
    send_bits(32'h0, 32, g);
    chk(g == m_reg[code[1:0]], tag, g, m_reg[code[1:0]]);
  endtask

  initial begin
    logic [31:0] g;
    m_reg[0] = '0; m_reg[1] = '0; m_reg[2] = 32'h0100_0000; m_reg[3] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    quiet = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(offset == 0, "R1 offset reset", offset, 0);
    chk(gain == 32'h0100_0000, "R1 gain reset", gain, 32'h0100_0000);
    chk(cfg == 0, "R1 config reset", cfg, 0);
    chk(sdo_en == 1'b0, "R2 hi-z while deselected", 32'(sdo_en), 0);

    // R1 flag clear after reset: command-phase sdo is 1
    tx_begin();
    send_bits(32'h02, 8, g);
    chk(g[6:0] == 7'h7F, "R1 idle flag on sdo", g, 32'h7F);
    send_bits(32'h8000_0001, 32, g);
    m_reg[2] = 32'h8000_0001;
    tx_end();
    chk(gain == 32'h8000_0001, "R3 gain write 0x02", gain, 32'h8000_0001);

    // R3 / R4 each register
    tx_begin(); do_write(8'h01, 32'hDEAD_BEEF); tx_end();
    tx_begin(); do_write(8'h03, 32'h1234_5678); tx_end();
    tx_begin(); do_read(8'h09, "R4 read offset"); tx_end();
    tx_begin(); do_read(8'h0A, "R4 read gain"); tx_end();
    tx_begin(); do_read(8'h0B, "R4 read config"); tx_end();

    // R5 three-wire back-to-back with select held low
    tx_begin();
    do_write(8'h02, 32'hA5A5_0F0F);
    do_read(8'h0A, "R5 back-to-back read");
    do_write(8'h01, 32'h0000_0003);
    do_read(8'h09, "R5 third access");
    tx_end();

    // R6 / R7 conversion read
    @(negedge clk); conv_data = 32'hC0FF_EE42; conv_valid = 1'b1;
    @(negedge clk); conv_valid = 1'b0; m_conv = 32'hC0FF_EE42; m_ready = 1'b1;
    tx_begin();
    send_bits(32'h0C, 8, g);
    chk(g[6:0] == 7'h00, "R7 ready flag shown low", g, 0);
    send_bits(32'h0, 8, g);
    chk(g[7:0] == 8'h00, "R7 flag during clear phase", g, 0);
    send_bits(32'h0, 32, g);
    chk(g == m_conv, "R6 conversion word", g, m_conv);
    m_ready = 1'b0;
    tx_end();
    tx_begin();
    send_bits(32'h0A, 8, g);
    chk(g[6:0] == 7'h7F, "R7 flag cleared after readout", g, 32'h7F);
    send_bits(32'h0, 32, g);
    chk(g == m_reg[2], "R4 read after conversion", g, m_reg[2]);
    tx_end();

    // R8 abort mid-command and mid-data
    tx_begin(); send_bits(32'h0, 4, g); tx_end();
    tx_begin(); send_bits(32'h02, 8, g); send_bits(32'hFFFF, 16, g); tx_end();
    chk(gain == m_reg[2], "R8 aborted write leaves gain", gain, m_reg[2]);
    tx_begin(); do_write(8'h03, 32'h0000_7E57); tx_end();
    chk(cfg == 32'h0000_7E57, "R8 access after abort", cfg, 32'h0000_7E57);

    // R9 unknown command then a valid one in the same select window
    tx_begin();
    send_bits(32'hF2, 8, g);
    send_bits(32'h0D, 8, g);
    do_write(8'h01, 32'h5555_AAAA);
    tx_end();
    chk(offset == 32'h5555_AAAA, "R9 unknown commands ignored", offset, 32'h5555_AAAA);
    chk(gain == m_reg[2], "R9 gain untouched", gain, m_reg[2]);

    // R10 clock edges while deselected
    for (int i = 0; i < 10; i++) begin
      sdi = 1'b1; sclk = 1'b1; repeat (HALF) @(negedge clk);
      sclk = 1'b0; repeat (HALF) @(negedge clk);
    end
    tx_begin(); do_read(8'h09, "R10 edges while deselected ignored"); tx_end();

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule